// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a core and its first-level cache controller and decides, in the cycle a memory request arrives, whether that request may go out. It keeps two small fully associative tables of cache-line addresses: one for read-class requests and one for write-class requests. A request is admitted when its line has no entry in either table. It is turned away as aliased when the line is already busy or locked by a locked read-modify-write. It is turned away as full when the outstanding limit is reached. An admitted request stays in its table until the matching completion for that line arrives on the read or write completion port.

Each request is decoded from its operation and qualifier flags into a primary type, which sets its class and is kept for tracking, and a secondary type, which goes to the cache controller. Four counters record each kind of alias conflict. A watchdog timer starts when the first request is admitted. It fires every `DL_THRESH` cycles while anything is outstanding and raises a sticky deadlock flag if any entry has been waiting longer than `DL_THRESH` cycles.

Top module: `mem_req_tracker`

## Requirements
- R1: While `outstanding >= MAX_OUT`, or while the table of the request's class has no free entry, a request gets status full (2). This check comes before every other check. Nothing is issued and no alias counter moves.
- R2: When `line_locked` is high, every request except a locked read-modify-write write (primary 7) gets status aliased (1) and no alias counter moves. A locked write to a locked line proceeds to the normal checks.
- R3: Write-class requests are those with primary types 1, 3, 4, 5, 6, 7 and 8. A write-class request whose line (address bits above the low `OFFSET_W` offset bits) is in the read table is aliased and increments `st_on_ld`. Otherwise, if its line is in the write table, it is aliased and increments `st_on_st`.
- R4: Read-class requests are those with primary types 0 and 2. A read-class request whose line is in the write table is aliased and increments `ld_on_st`. Otherwise, if its line is in the read table, it is aliased and increments `ld_on_ld`. Issued and full requests leave all four counters unchanged.
- R5: Type codes are LD=0, ST=1, IFETCH=2, RMW_READ=3, LL=4, SC=5, LOCK_RD=6, LOCK_WR=7, FLUSH=8, ATOMIC=9. The op field is read=0, write=1, swap=2, flush=3, and swap decodes as a write. The decoded (primary, secondary) pair is chosen by the first rule that applies:
  - flush gives (8,8);
  - `req_llsc` gives (5,9) for a write and (4,9) for a read;
  - `req_locked` gives (7,1) for a write and (6,1) for a read;
  - a write gives (1,1);
  - `req_ifetch` gives (2,2);
  - `req_store_chk` gives (3,1);
  - any other read gives (0,0).
- R6: `outstanding` always equals the number of valid entries in both tables. Each admission adds one. A completion whose line is in the matching table removes that entry. A completion for a line that is not present changes nothing.
- R7: The watchdog is armed `DL_THRESH` cycles ahead on an admission while it is idle. Each time it expires it re-arms if requests remain. On expiry it sets `deadlock` if an entry's age exceeds `DL_THRESH`, and `deadlock` then holds until reset.
- R8: After reset the tables are empty, `outstanding`, all four counters and `deadlock` are zero.
- R9: `resp_status` is issued (0) for an admitted request, and `iss_valid` is high exactly when `req_valid` is high and the status is issued. When `iss_valid` is high, `iss_addr` carries the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_op | input | 2 | 0 read, 1 write, 2 swap, 3 flush |
| req_llsc | input | 1 | Load-linked / store-conditional qualifier |
| req_locked | input | 1 | Locked read-modify-write qualifier |
| req_ifetch | input | 1 | Instruction fetch qualifier |
| req_store_chk | input | 1 | Read that needs write permission |
| line_locked | input | 1 | The request's line is held by a locked read-modify-write |
| rd_done | input | 1 | Read completion strobe |
| rd_done_line | input | ADDR_W-OFFSET_W | Line address of the read completion |
| wr_done | input | 1 | Write completion strobe |
| wr_done_line | input | ADDR_W-OFFSET_W | Line address of the write completion |
| resp_status | output | 2 | 0 issued, 1 aliased, 2 full |
| iss_valid | output | 1 | Request forwarded to the cache controller |
| iss_addr | output | ADDR_W | Forwarded address |
| iss_primary | output | 4 | Primary type of the request |
| iss_secondary | output | 4 | Secondary type sent with the request |
| outstanding | output | $clog2(2*ENTRIES+1) | Number of entries held |
| st_on_ld | output | CNT_W | Count of write-class requests blocked by a read entry |
| st_on_st | output | CNT_W | Count of write-class requests blocked by a write entry |
| ld_on_st | output | CNT_W | Count of read-class requests blocked by a write entry |
| ld_on_ld | output | CNT_W | Count of read-class requests blocked by a read entry |
| deadlock | output | 1 | Sticky flag for an entry held too long |

## Verification
Status, issue strobe, address and both type codes are combinational and belong to the same cycle as the request. The bench reads them one time unit after it drives the inputs, well before the next rising edge. The table contents, `outstanding` and the four counters change at the rising edge that accepts the request or completion. The bench compares them against its model at the following falling edge, before it drives the next request. The deadlock flag is sampled twenty cycles after an admission, where an entry aged exactly `DL_THRESH` must not trip it, and again after forty cycles, past the second expiry, where it must be set. It is then sampled after the entry is completed to confirm that it stays set.

// File: rtl/mem_req_tracker.sv
`timescale 1ns/1ps
module mem_req_tracker #(
  parameter int ADDR_W    = 32,
  parameter int OFFSET_W  = 6,
  parameter int ENTRIES   = 8,
  parameter int MAX_OUT   = 6,
  parameter int DL_THRESH = 1000,
  parameter int CNT_W     = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_addr,
  input  logic [1:0]                     req_op,
  input  logic                           req_llsc,
  input  logic                           req_locked,
  input  logic                           req_ifetch,
  input  logic                           req_store_chk,
  input  logic                           line_locked,
  input  logic                           rd_done,
  input  logic [ADDR_W-OFFSET_W-1:0]     rd_done_line,
  input  logic                           wr_done,
  input  logic [ADDR_W-OFFSET_W-1:0]     wr_done_line,
  output logic [1:0]                     resp_status,
  output logic                           iss_valid,
  output logic [ADDR_W-1:0]              iss_addr,
  output logic [3:0]                     iss_primary,
  output logic [3:0]                     iss_secondary,
  output logic [$clog2(2*ENTRIES+1)-1:0] outstanding,
  output logic [CNT_W-1:0]               st_on_ld,
  output logic [CNT_W-1:0]               st_on_st,
  output logic [CNT_W-1:0]               ld_on_st,
  output logic [CNT_W-1:0]               ld_on_ld,
  output logic                           deadlock
);
  localparam int LINE_W = ADDR_W - OFFSET_W;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int OUT_W  = $clog2(2*ENTRIES+1);
  localparam int TMR_W  = $clog2(DL_THRESH+1);
  localparam int CYC_W  = TMR_W + 2;

  localparam logic [3:0] T_LD = 4'd0, T_ST = 4'd1, T_IF = 4'd2, T_RMWRD = 4'd3,
                         T_LL = 4'd4, T_SC = 4'd5, T_LKRD = 4'd6, T_LKWR = 4'd7,
                         T_FL = 4'd8, T_AT = 4'd9;
  localparam logic [1:0] S_ISS = 2'd0, S_ALIAS = 2'd1, S_FULL = 2'd2;

  logic [LINE_W-1:0] rd_line [ENTRIES];
  logic [LINE_W-1:0] wr_line [ENTRIES];
  logic [CYC_W-1:0]  rd_t    [ENTRIES];
  logic [CYC_W-1:0]  wr_t    [ENTRIES];
  logic [ENTRIES-1:0] rd_v, wr_v, rd_hit, wr_hit, rd_dhit, wr_dhit, rd_old, wr_old;

  logic [LINE_W-1:0] req_line;
  logic [3:0] prim, sec;
  logic wr_cls, admit, rd_rm, wr_rm;
  logic al_sol, al_sos, al_los, al_lol;
  logic [IDX_W-1:0] rd_slot, wr_slot;
  logic [OUT_W-1:0] out_nxt;
  logic [CYC_W-1:0] cyc;
  logic [TMR_W-1:0] tmr;
  logic armed;

  assign req_line = req_addr[ADDR_W-1:OFFSET_W];
  wire is_wr = (req_op == 2'd1) || (req_op == 2'd2);

  always_comb begin
    if (req_op == 2'd3)  begin prim = T_FL; sec = T_FL; end
    else if (req_llsc)   begin prim = is_wr ? T_SC : T_LL; sec = T_AT; end
    else if (req_locked) begin prim = is_wr ? T_LKWR : T_LKRD; sec = T_ST; end
    else if (is_wr)      begin prim = T_ST; sec = T_ST; end
    else if (req_ifetch) begin prim = T_IF; sec = T_IF; end
    else if (req_store_chk) begin prim = T_RMWRD; sec = T_ST; end
    else                 begin prim = T_LD; sec = T_LD; end
  end

  assign wr_cls = !(prim == T_LD || prim == T_IF);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cam
    assign rd_hit[g]  = rd_v[g] && (rd_line[g] == req_line);
    assign wr_hit[g]  = wr_v[g] && (wr_line[g] == req_line);
    assign rd_dhit[g] = rd_v[g] && (rd_line[g] == rd_done_line);
    assign wr_dhit[g] = wr_v[g] && (wr_line[g] == wr_done_line);
    assign rd_old[g]  = rd_v[g] && ((cyc - rd_t[g]) > CYC_W'(DL_THRESH));
    assign wr_old[g]  = wr_v[g] && ((cyc - wr_t[g]) > CYC_W'(DL_THRESH));
  end

  function automatic logic [IDX_W-1:0] first_free(input logic [ENTRIES-1:0] v);
    first_free = '0;
    for (int i = ENTRIES-1; i >= 0; i--) if (!v[i]) first_free = IDX_W'(i);
  endfunction

  assign rd_slot = first_free(rd_v);
  assign wr_slot = first_free(wr_v);

  always_comb begin
    resp_status = S_ISS;
    {al_sol, al_sos, al_los, al_lol} = 4'b0;
    if (outstanding >= OUT_W'(MAX_OUT) || (wr_cls ? &wr_v : &rd_v)) resp_status = S_FULL;
    else if (line_locked && prim != T_LKWR) resp_status = S_ALIAS;
    else if (wr_cls && |rd_hit)  begin resp_status = S_ALIAS; al_sol = 1'b1; end
    else if (wr_cls && |wr_hit)  begin resp_status = S_ALIAS; al_sos = 1'b1; end
    else if (!wr_cls && |wr_hit) begin resp_status = S_ALIAS; al_los = 1'b1; end
    else if (!wr_cls && |rd_hit) begin resp_status = S_ALIAS; al_lol = 1'b1; end
  end

  assign admit         = req_valid && (resp_status == S_ISS);
  assign iss_valid     = admit;
  assign iss_addr      = req_addr;
  assign iss_primary   = prim;
  assign iss_secondary = sec;
  assign rd_rm         = rd_done && |rd_dhit;
  assign wr_rm         = wr_done && |wr_dhit;
  assign out_nxt       = outstanding + OUT_W'(admit) - OUT_W'(rd_rm) - OUT_W'(wr_rm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_v <= '0;
      wr_v <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        rd_line[i] <= '0; wr_line[i] <= '0; rd_t[i] <= '0; wr_t[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (rd_done && rd_dhit[i]) rd_v[i] <= 1'b0;
        if (wr_done && wr_dhit[i]) wr_v[i] <= 1'b0;
        if (admit && !wr_cls && rd_slot == IDX_W'(i)) begin
          rd_v[i] <= 1'b1; rd_line[i] <= req_line; rd_t[i] <= cyc;
        end
        if (admit && wr_cls && wr_slot == IDX_W'(i)) begin
          wr_v[i] <= 1'b1; wr_line[i] <= req_line; wr_t[i] <= cyc;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding <= '0;
      st_on_ld <= '0; st_on_st <= '0; ld_on_st <= '0; ld_on_ld <= '0;
    end else begin
      outstanding <= out_nxt;
      st_on_ld <= st_on_ld + CNT_W'(req_valid && al_sol);
      st_on_st <= st_on_st + CNT_W'(req_valid && al_sos);
      ld_on_st <= ld_on_st + CNT_W'(req_valid && al_los);
      ld_on_ld <= ld_on_ld + CNT_W'(req_valid && al_lol);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= '0; tmr <= '0; armed <= 1'b0; deadlock <= 1'b0;
    end else begin
      cyc <= cyc + 1'b1;
      if (armed) begin
        if (tmr == TMR_W'(1)) begin
          if (|rd_old || |wr_old) deadlock <= 1'b1;
          if (out_nxt != '0) tmr <= TMR_W'(DL_THRESH);
          else armed <= 1'b0;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end else if (admit) begin
        armed <= 1'b1;
        tmr <= TMR_W'(DL_THRESH);
      end
    end
  end
endmodule

// File: rtl/mem_req_tracker_chk.sv
`timescale 1ns/1ps
module mem_req_tracker_chk #(
  parameter int ENTRIES = 8,
  parameter int MAX_OUT = 6,
  parameter int CNT_W   = 16,
  parameter int OUT_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               line_locked,
  input logic [1:0]         resp_status,
  input logic               iss_valid,
  input logic [3:0]         iss_primary,
  input logic [3:0]         iss_secondary,
  input logic [OUT_W-1:0]   outstanding,
  input logic [ENTRIES-1:0] rd_v,
  input logic [ENTRIES-1:0] wr_v,
  input logic [CNT_W-1:0]   st_on_ld,
  input logic [CNT_W-1:0]   st_on_st,
  input logic [CNT_W-1:0]   ld_on_st,
  input logic [CNT_W-1:0]   ld_on_ld,
  input logic               deadlock
);
  p_full_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && outstanding >= OUT_W'(MAX_OUT) |-> resp_status == 2'd2 && !iss_valid);

  p_locked_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && line_locked && iss_primary != 4'd7 |-> !iss_valid);

  p_issue_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && resp_status != 2'd1 |=>
      $stable(st_on_ld) && $stable(st_on_st) && $stable(ld_on_st) && $stable(ld_on_ld));

  p_atomic_sec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid && (iss_primary == 4'd4 || iss_primary == 4'd5) |-> iss_secondary == 4'd9);

  p_count_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding == OUT_W'($countones(rd_v) + $countones(wr_v)));

  p_sticky_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    deadlock |=> deadlock);

  p_issue_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> req_valid && resp_status == 2'd0);
endmodule

bind mem_req_tracker mem_req_tracker_chk #(
  .ENTRIES(ENTRIES), .MAX_OUT(MAX_OUT), .CNT_W(CNT_W), .OUT_W($clog2(2*ENTRIES+1))
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .line_locked(line_locked),
  .resp_status(resp_status), .iss_valid(iss_valid), .iss_primary(iss_primary),
  .iss_secondary(iss_secondary), .outstanding(outstanding), .rd_v(rd_v), .wr_v(wr_v),
  .st_on_ld(st_on_ld), .st_on_st(st_on_st), .ld_on_st(ld_on_st), .ld_on_ld(ld_on_ld),
  .deadlock(deadlock)
);

// File: tb/tb_mem_req_tracker.sv
`timescale 1ns/1ps
module tb_mem_req_tracker;
  localparam int NE = 8;
  localparam int MAXO = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_llsc = 0, req_locked = 0, req_ifetch = 0, req_store_chk = 0;
  logic line_locked = 0, rd_done = 0, wr_done = 0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_op = '0;
  logic [25:0] rd_done_line = '0, wr_done_line = '0;
  logic [1:0]  resp_status;
  logic        iss_valid, deadlock;
  logic [31:0] iss_addr;
  logic [3:0]  iss_primary, iss_secondary;
  logic [4:0]  outstanding;
  logic [15:0] st_on_ld, st_on_st, ld_on_st, ld_on_ld;

  mem_req_tracker #(.DL_THRESH(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_op(req_op),
    .req_llsc(req_llsc), .req_locked(req_locked), .req_ifetch(req_ifetch),
    .req_store_chk(req_store_chk), .line_locked(line_locked), .rd_done(rd_done),
    .rd_done_line(rd_done_line), .wr_done(wr_done), .wr_done_line(wr_done_line),
    .resp_status(resp_status), .iss_valid(iss_valid), .iss_addr(iss_addr),
    .iss_primary(iss_primary), .iss_secondary(iss_secondary), .outstanding(outstanding),
    .st_on_ld(st_on_ld), .st_on_st(st_on_st), .ld_on_st(ld_on_st), .ld_on_ld(ld_on_ld),
    .deadlock(deadlock));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, wd = 0;
  bit finished = 0;
  logic [25:0] mrl [NE];
  logic [25:0] mwl [NE];
  bit mrv [NE];
  bit mwv [NE];
  int e_out, e_sol, e_sos, e_los, e_lol;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_types(input logic [1:0] op, input bit ll, lk, ifc, sck);
    bit w = (op == 2'd1) || (op == 2'd2);
    if (op == 2'd3) return {4'd8, 4'd8};
    if (ll) return {w ? 4'd5 : 4'd4, 4'd9};
    if (lk) return {w ? 4'd7 : 4'd6, 4'd1};
    if (w) return {4'd1, 4'd1};
    if (ifc) return {4'd2, 4'd2};
    if (sck) return {4'd3, 4'd1};
    return {4'd0, 4'd0};
  endfunction

  function automatic bit in_tbl(input bit rd, input logic [25:0] l);
    for (int i = 0; i < NE; i++)
      if (rd ? (mrv[i] && mrl[i] == l) : (mwv[i] && mwl[i] == l)) return 1;
    return 0;
  endfunction

  function automatic int used(input bit rd);
    int n = 0;
    for (int i = 0; i < NE; i++) n += rd ? int'(mrv[i]) : int'(mwv[i]);
    return n;
  endfunction

  task automatic clear_model();
    for (int i = 0; i < NE; i++) begin mrv[i] = 0; mwv[i] = 0; end
    e_out = 0; e_sol = 0; e_sos = 0; e_los = 0; e_lol = 0;
  endtask

  task automatic step(input bit v, input logic [31:0] a, input logic [1:0] op,
                      input bit ll, lk, ifc, sck, blk,
                      input bit rdd, input logic [25:0] rdl, input bit wrd, input logic [25:0] wrl);
    logic [7:0] t;
    bit wc, iss, rdh, wrh;
    logic [1:0] es;
    string tag;
    logic [25:0] l;
    @(negedge clk);
    check("R6 outstanding", outstanding, e_out);
    check("R3 st_on_ld", st_on_ld, e_sol);
    check("R3 st_on_st", st_on_st, e_sos);
    check("R4 ld_on_st", ld_on_st, e_los);
    check("R4 ld_on_ld", ld_on_ld, e_lol);
    req_valid = v; req_addr = a; req_op = op; req_llsc = ll; req_locked = lk;
    req_ifetch = ifc; req_store_chk = sck; line_locked = blk;
    rd_done = rdd; rd_done_line = rdl; wr_done = wrd; wr_done_line = wrl;
    #1;
    iss = 0;
    if (v) begin
      t = exp_types(op, ll, lk, ifc, sck);
      wc = !(t[7:4] == 4'd0 || t[7:4] == 4'd2);
      l = a[31:6];
      rdh = in_tbl(1, l); wrh = in_tbl(0, l);
      if (e_out >= MAXO || used(!wc) == NE) begin es = 2; tag = "R1 status"; end
      else if (blk && t[7:4] != 4'd7) begin es = 1; tag = "R2 status"; end
      else if (wc && rdh) begin es = 1; tag = "R3 status"; e_sol++; end
      else if (wc && wrh) begin es = 1; tag = "R3 status"; e_sos++; end
      else if (!wc && wrh) begin es = 1; tag = "R4 status"; e_los++; end
      else if (!wc && rdh) begin es = 1; tag = "R4 status"; e_lol++; end
      else begin es = 0; tag = "R9 status"; iss = 1; end
      check(tag, resp_status, es);
      check("R9 iss_valid", iss_valid, iss);
      if (iss) begin
        check("R5 primary", iss_primary, t[7:4]);
        check("R5 secondary", iss_secondary, t[3:0]);
        check("R9 iss_addr", iss_addr, a);
      end
    end else begin
      check("R9 iss_valid idle", iss_valid, 0);
    end
    if (rdd) for (int i = 0; i < NE; i++) if (mrv[i] && mrl[i] == rdl) begin mrv[i] = 0; e_out--; end
    if (wrd) for (int i = 0; i < NE; i++) if (mwv[i] && mwl[i] == wrl) begin mwv[i] = 0; e_out--; end
    if (iss) begin
      e_out++;
      for (int i = 0; i < NE; i++) begin
        if (!wc && !mrv[i]) begin mrv[i] = 1; mrl[i] = l; break; end
        if (wc && !mwv[i]) begin mwv[i] = 1; mwl[i] = l; break; end
      end
    end
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rq(input logic [31:0] a, input logic [1:0] op, input bit ll, lk, ifc, sck, blk);
    step(1, a, op, ll, lk, ifc, sck, blk, 0, 0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    req_valid = 0; rd_done = 0; wr_done = 0; line_locked = 0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R8 outstanding", outstanding, 0);
    check("R8 deadlock", deadlock, 0);
    check("R8 counters", {st_on_ld, st_on_st, ld_on_st, ld_on_ld}, 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    rq(32'h40, 0, 0, 0, 0, 0, 0);
    repeat (20) idle();
    check("R7 no flag at exact threshold", deadlock, 0);
    repeat (20) idle();
    check("R7 flag after second expiry", deadlock, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 26'h1, 0, 0);
    repeat (3) idle();
    check("R7 flag sticky", deadlock, 1);
    do_reset();

    rq(32'h40, 0, 0, 0, 0, 0, 0);
    rq(32'h44, 1, 0, 0, 0, 0, 0);
    rq(32'h48, 0, 0, 0, 0, 0, 0);
    rq(32'h80, 1, 0, 0, 0, 0, 0);
    rq(32'h8C, 0, 0, 0, 0, 0, 0);
    rq(32'h90, 1, 0, 0, 0, 0, 0);
    rq(32'h100, 0, 1, 0, 0, 0, 0);
    rq(32'h140, 1, 1, 0, 0, 0, 0);
    rq(32'h180, 0, 0, 1, 0, 0, 0);
    rq(32'h1C0, 2, 0, 0, 0, 0, 0);
    rq(32'h200, 0, 0, 0, 0, 0, 0);
    rq(32'h200, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 26'h1, 1, 26'hC0);
    rq(32'h200, 0, 0, 0, 0, 0, 1);
    rq(32'h200, 1, 0, 1, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 26'h2);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 26'h4);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 26'h5);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 26'h6);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 26'h7);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 26'h8);
    rq(32'h240, 0, 0, 0, 1, 0, 0);
    rq(32'h280, 0, 0, 0, 0, 1, 0);
    rq(32'h2C0, 3, 1, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 26'h9, 1, 26'hA);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 26'hB);
    idle();
    check("R6 drained", outstanding, 0);

    for (int n = 0; n < 4000; n++) begin
      logic [25:0] ra, wa;
      int k;
      k = $urandom % NE;
      ra = mrv[k] ? mrl[k] : 26'($urandom % 12 + 1);
      k = $urandom % NE;
      wa = mwv[k] ? mwl[k] : 26'($urandom % 12 + 1);
      step($urandom % 4 != 0, {26'($urandom % 12 + 1), 6'($urandom)}, 2'($urandom),
           $urandom % 5 == 0, $urandom % 5 == 0, $urandom % 4 == 0, $urandom % 4 == 0,
           $urandom % 8 == 0, $urandom % 3 == 0, ra, $urandom % 3 == 0, wa);
    end
    idle();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule